// File: doc/BRIEF.md
# Endpoint Buffer Region Allocator

This block divides one shared packet buffer among the endpoints of a USB device. Each endpoint is given a region whose length is its packet size times its bank count. A region starts where the nearest lower-numbered reserved endpoint ends. Commands arrive on a one-cycle command port. They set or clear an endpoint's enable bit, reserve a region, or release one. A combinational lookup port returns the start address, length and fit flag of any endpoint.

Start addresses are held in registers, not recomputed as a running sum. Reserving or releasing endpoint k places or clears k itself and moves only endpoint k+1, if k+1 holds a region. Endpoints k+2 and above keep their start addresses, even when the result is a gap or an overlap. Firmware is expected to reserve endpoints from 0 upward, and in that order the packing is contiguous. Data is not copied when a region moves. A region that runs past the end of the buffer clears that endpoint's fit flag and raises the overflow output.

Top module: `epbuf_alloc`

## Requirements
- R1: After a synchronous active-high reset, no endpoint is enabled or reserved, every lookup returns start 0, length 0 and fit 0, and overflow is low.
- R2: A region's length is the packet size times the bank count. The packet size is 8 bytes shifted left by the 2-bit size code (8, 16, 32, 64). Bank bit 0 means one bank and 1 means two.
- R3: Command op 2 (reserve) on an endpoint that holds no region stores its size and bank. Its start becomes the end (start plus length) of the highest-numbered reserved endpoint below it, or 0 if there is none.
- R4: When endpoint k is reserved and endpoint k+1 already holds a region, the start of k+1 becomes the new end of k. Endpoints k+2 and above keep their starts.
- R5: Command op 3 (release) on a reserved endpoint k frees it, and it then reports start 0 and length 0. If k+1 holds a region, its start takes the old start of k. Endpoints k+2 and above keep their starts.
- R6: Command ops 0 (set enable) and 1 (clear enable) change only the enable bit. The reservation, size, bank and every start address stay as they were.
- R7: An endpoint's fit flag is 1 only while it is reserved and its start plus length is at most the buffer depth (176). Overflow is high exactly when some reserved endpoint has a clear fit flag.
- R8: A reserve on an already reserved endpoint is ignored, and so is a release on an endpoint with no region. Neither changes any size, length or start.
- R9: The lookup outputs follow the requested endpoint number in the same cycle. An endpoint number at or above the endpoint count returns all zeros. A command becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 set enable, 1 clear enable, 2 reserve, 3 release |
| cmd_ep | input | 3 | Endpoint the command addresses |
| cmd_size | input | 2 | Packet size code used by reserve |
| cmd_bank | input | 1 | Bank count code used by reserve (0 one, 1 two) |
| lk_ep | input | 3 | Endpoint number to look up |
| lk_base | output | 10 | Start address of the looked-up region |
| lk_len | output | 8 | Length in bytes of the looked-up region |
| lk_ok | output | 1 | Fit flag of the looked-up endpoint |
| ep_enabled | output | 5 | Enable bit of each endpoint |
| ep_alloc | output | 5 | Reservation bit of each endpoint |
| ep_cfg_ok | output | 5 | Fit flag of each endpoint |
| overflow | output | 1 | Some reserved region runs past the buffer end |

## Verification
A wrong start register shows up at the lookup port in the cycle after the faulty command. If the wrong region is the one the bench looks up, the error also shows in that endpoint's fit flag and the overflow output in the same cycle. A wrong rule for which endpoint moves only becomes visible on a command out of order or in the middle of the stack. For that reason the bench reserves an endpoint out of order, releases one in the middle, and reads back both the neighbour and the endpoints above it. A stale size after an ignored command is caught through the lookup length, and through the start address of the next endpoint up.

// File: rtl/epbuf_alloc_pkg.sv
package epbuf_alloc_pkg;

  typedef enum logic [1:0] {
    OP_EN_SET = 2'd0,
    OP_EN_CLR = 2'd1,
    OP_ALLOC  = 2'd2,
    OP_FREE   = 2'd3
  } ep_op_e;

  // region length in bytes: base packet shifted by size code, doubled for two banks
  function automatic int unsigned region_len(input int unsigned min_pkt,
                                             input logic [1:0] size_code,
                                             input logic bank_code);
    int unsigned pkt;
    pkt = min_pkt << size_code;
    return bank_code ? (pkt * 2) : pkt;
  endfunction

endpackage

// File: rtl/epbuf_cfg_bank.sv
module epbuf_cfg_bank
  import epbuf_alloc_pkg::*;
#(
  parameter int NUM_EP  = 5,
  parameter int MIN_PKT = 8,
  parameter int EP_W    = 3,
  parameter int LEN_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [EP_W-1:0]              cmd_ep,
  input  logic [1:0]                   cmd_size,
  input  logic                         cmd_bank,
  output logic [NUM_EP-1:0]            en_q,
  output logic [NUM_EP-1:0]            alloc_q,
  output logic [NUM_EP-1:0][LEN_W-1:0] len_o
);

  logic [NUM_EP-1:0][1:0] size_q;
  logic [NUM_EP-1:0]      bank_q;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit;
    assign hit = cmd_valid && (cmd_ep == EP_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]    <= 1'b0;
        alloc_q[i] <= 1'b0;
        size_q[i]  <= 2'd0;
        bank_q[i]  <= 1'b0;
      end else if (hit) begin
        case (ep_op_e'(cmd_op))
          OP_EN_SET: en_q[i] <= 1'b1;
          OP_EN_CLR: en_q[i] <= 1'b0;
          OP_ALLOC: if (!alloc_q[i]) begin
            alloc_q[i] <= 1'b1;
            size_q[i]  <= cmd_size;
            bank_q[i]  <= cmd_bank;
          end
          OP_FREE: alloc_q[i] <= 1'b0;
          default: ;
        endcase
      end
    end

    assign len_o[i] = LEN_W'(region_len(MIN_PKT, size_q[i], bank_q[i]));

    // R6: enable commands leave reservation and shape alone
    p_enable_only_r6: assert property (@(posedge clk) disable iff (rst)
      (hit && (cmd_op == OP_EN_SET || cmd_op == OP_EN_CLR))
      |=> ($stable(alloc_q[i]) && $stable(size_q[i]) && $stable(bank_q[i])));

    // R8: re-reserving a reserved endpoint keeps its shape
    p_realloc_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (hit && cmd_op == OP_ALLOC && alloc_q[i])
      |=> ($stable(size_q[i]) && $stable(bank_q[i]) && alloc_q[i]));
  end

  // R1: reset clears all endpoint state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (alloc_q == '0 && en_q == '0));

endmodule

// File: rtl/epbuf_base_track.sv
module epbuf_base_track
  import epbuf_alloc_pkg::*;
#(
  parameter int NUM_EP  = 5,
  parameter int MIN_PKT = 8,
  parameter int EP_W    = 3,
  parameter int LEN_W   = 8,
  parameter int SUM_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [EP_W-1:0]              cmd_ep,
  input  logic [1:0]                   cmd_size,
  input  logic                         cmd_bank,
  input  logic [NUM_EP-1:0]            alloc_q,
  input  logic [NUM_EP-1:0][LEN_W-1:0] len_i,
  output logic [NUM_EP-1:0][SUM_W-1:0] base_q
);

  logic [NUM_EP-1:0][SUM_W-1:0] lower_end;
  logic [NUM_EP-1:0][SUM_W-1:0] base_d;
  logic [SUM_W-1:0]             new_len;

  assign new_len = SUM_W'(region_len(MIN_PKT, cmd_size, cmd_bank));

  // end of the highest reserved region below each endpoint
  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      lower_end[i] = '0;
      for (int j = 0; j < i; j++) begin
        if (alloc_q[j]) lower_end[i] = base_q[j] + SUM_W'(len_i[j]);
      end
    end
  end

  always_comb begin
    base_d = base_q;
    if (cmd_valid) begin
      for (int k = 0; k < NUM_EP; k++) begin
        if (cmd_ep == EP_W'(k)) begin
          if (cmd_op == OP_ALLOC && !alloc_q[k]) begin
            base_d[k] = lower_end[k];
            if (k + 1 < NUM_EP) begin
              if (alloc_q[k+1]) base_d[k+1] = lower_end[k] + new_len;
            end
          end else if (cmd_op == OP_FREE && alloc_q[k]) begin
            base_d[k] = '0;
            if (k + 1 < NUM_EP) begin
              if (alloc_q[k+1]) base_d[k+1] = base_q[k];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_d;
  end

  // R9: without a command no start address changes
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(base_q));

  for (genvar i = 2; i < NUM_EP; i++) begin : g_far
    // R4 / R5: endpoints two or more above the command never move
    p_far_fixed_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ep < EP_W'(i - 1)) |=> $stable(base_q[i]));
  end

endmodule

// File: rtl/epbuf_fit_check.sv
module epbuf_fit_check #(
  parameter int NUM_EP = 5,
  parameter int DEPTH  = 176,
  parameter int LEN_W  = 8,
  parameter int SUM_W  = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_EP-1:0]            alloc_q,
  input  logic [NUM_EP-1:0][SUM_W-1:0] base_q,
  input  logic [NUM_EP-1:0][LEN_W-1:0] len_i,
  output logic [NUM_EP-1:0]            cfg_ok,
  output logic                         overflow
);

  localparam int CMP_W = SUM_W + 1;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_fit
    logic [CMP_W-1:0] end_addr;
    assign end_addr  = CMP_W'(base_q[i]) + CMP_W'(len_i[i]);
    assign cfg_ok[i] = alloc_q[i] && (end_addr <= CMP_W'(DEPTH));

    // R7: a fit flag never stands for an unreserved endpoint
    p_ok_needs_alloc_r7: assert property (@(posedge clk) disable iff (rst)
      cfg_ok[i] |-> alloc_q[i]);
  end

  assign overflow = |(alloc_q & ~cfg_ok);

endmodule

// File: rtl/epbuf_alloc.sv
module epbuf_alloc #(
  parameter int NUM_EP  = 5,
  parameter int DEPTH   = 176,
  parameter int MIN_PKT = 8,
  parameter int EP_W    = $clog2(NUM_EP),
  parameter int LEN_W   = $clog2(MIN_PKT * 16 + 1),
  parameter int SUM_W   = $clog2(DEPTH + NUM_EP * MIN_PKT * 16 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [EP_W-1:0]   cmd_ep,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_bank,
  input  logic [EP_W-1:0]   lk_ep,
  output logic [SUM_W-1:0]  lk_base,
  output logic [LEN_W-1:0]  lk_len,
  output logic              lk_ok,
  output logic [NUM_EP-1:0] ep_enabled,
  output logic [NUM_EP-1:0] ep_alloc,
  output logic [NUM_EP-1:0] ep_cfg_ok,
  output logic              overflow
);

  logic [NUM_EP-1:0]            alloc_q;
  logic [NUM_EP-1:0][LEN_W-1:0] len_w;
  logic [NUM_EP-1:0][SUM_W-1:0] base_w;

  epbuf_cfg_bank #(
    .NUM_EP(NUM_EP), .MIN_PKT(MIN_PKT), .EP_W(EP_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ep(cmd_ep), .cmd_size(cmd_size), .cmd_bank(cmd_bank),
    .en_q(ep_enabled), .alloc_q(alloc_q), .len_o(len_w)
  );

  epbuf_base_track #(
    .NUM_EP(NUM_EP), .MIN_PKT(MIN_PKT), .EP_W(EP_W), .LEN_W(LEN_W), .SUM_W(SUM_W)
  ) u_base (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ep(cmd_ep), .cmd_size(cmd_size), .cmd_bank(cmd_bank),
    .alloc_q(alloc_q), .len_i(len_w), .base_q(base_w)
  );

  epbuf_fit_check #(
    .NUM_EP(NUM_EP), .DEPTH(DEPTH), .LEN_W(LEN_W), .SUM_W(SUM_W)
  ) u_fit (
    .clk(clk), .rst(rst), .alloc_q(alloc_q), .base_q(base_w),
    .len_i(len_w), .cfg_ok(ep_cfg_ok), .overflow(overflow)
  );

  assign ep_alloc = alloc_q;

  always_comb begin
    lk_base = '0;
    lk_len  = '0;
    lk_ok   = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (lk_ep == EP_W'(i) && alloc_q[i]) begin
        lk_base = base_w[i];
        lk_len  = len_w[i];
        lk_ok   = ep_cfg_ok[i];
      end
    end
  end

  // R2: a reported length is always a single power of two
  p_len_pow2_r2: assert property (@(posedge clk) disable iff (rst)
    (lk_len != '0) |-> ($countones(lk_len) == 1));

endmodule

// File: tb/epbuf_alloc_test.sv
module epbuf_alloc_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_ep = 3'd0;
  logic [1:0] cmd_size = 2'd0;
  logic       cmd_bank = 1'b0;
  logic [2:0] lk_ep = 3'd0;
  logic [9:0] lk_base;
  logic [7:0] lk_len;
  logic       lk_ok;
  logic [4:0] ep_enabled, ep_alloc, ep_cfg_ok;
  logic       overflow;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  epbuf_alloc uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ep(cmd_ep), .cmd_size(cmd_size), .cmd_bank(cmd_bank),
    .lk_ep(lk_ep), .lk_base(lk_base), .lk_len(lk_len), .lk_ok(lk_ok),
    .ep_enabled(ep_enabled), .ep_alloc(ep_alloc), .ep_cfg_ok(ep_cfg_ok),
    .overflow(overflow)
  );

  // {op[2], ep[3], size[2], bank, check_ep[3], base[10], len[8], ok}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 3'd0, 2'd1, 1'b0, 3'd0, 10'd0,   8'd16, 1'b1},  // R3 first region at 0
    {2'd2, 3'd2, 2'd2, 1'b1, 3'd2, 10'd16,  8'd64, 1'b1},  // R2 R3 skip over ep1
    {2'd2, 3'd3, 2'd1, 1'b1, 3'd3, 10'd80,  8'd32, 1'b1},
    {2'd2, 3'd4, 2'd0, 1'b0, 3'd4, 10'd112, 8'd8,  1'b1},
    {2'd2, 3'd1, 2'd1, 1'b0, 3'd1, 10'd16,  8'd16, 1'b1},  // R3 out of order
    {2'd0, 3'd2, 2'd0, 1'b0, 3'd2, 10'd32,  8'd64, 1'b1},  // R4 neighbour moved up
    {2'd0, 3'd3, 2'd0, 1'b0, 3'd3, 10'd80,  8'd32, 1'b1},  // R4 k+2 stays
    {2'd1, 3'd4, 2'd0, 1'b0, 3'd4, 10'd112, 8'd8,  1'b1},  // R6 disable keeps region
    {2'd3, 3'd1, 2'd0, 1'b0, 3'd2, 10'd16,  8'd64, 1'b1},  // R5 neighbour slides down
    {2'd0, 3'd0, 2'd0, 1'b0, 3'd1, 10'd0,   8'd0,  1'b0},  // R5 freed reports zero
    {2'd0, 3'd1, 2'd0, 1'b0, 3'd3, 10'd80,  8'd32, 1'b1},  // R5 k+2 stays
    {2'd0, 3'd4, 2'd0, 1'b0, 3'd4, 10'd112, 8'd8,  1'b1}   // R6
  };

  task automatic do_cmd(input logic [1:0] op, input logic [2:0] ep,
                        input logic [1:0] sz, input logic bk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ep = ep; cmd_size = sz; cmd_bank = bk;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic check_ep(input string req, input logic [2:0] ep,
                          input logic [9:0] eb, input logic [7:0] el, input logic eo);
    lk_ep = ep;
    #1;
    n_vec++;
    if (lk_base !== eb || lk_len !== el || lk_ok !== eo) begin
      n_bad++;
      $display("FAIL %s ep%0d: got base=%0d len=%0d ok=%0b, expected base=%0d len=%0d ok=%0b",
               req, ep, lk_base, lk_len, lk_ok, eb, el, eo);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b, expected %0b", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int e = 0; e < 5; e++) check_ep("R1", 3'(e), 10'd0, 8'd0, 1'b0);
    check_bit("R1 alloc", ep_alloc == 5'd0, 1'b1);
    check_bit("R1 enable", ep_enabled == 5'd0, 1'b1);
    check_bit("R1 overflow", overflow, 1'b0);

    for (int v = 0; v < NV; v++) begin
      do_cmd(VEC[v][29:28], VEC[v][27:25], VEC[v][24:23], VEC[v][22]);
      check_ep($sformatf("vector %0d", v), VEC[v][21:19], VEC[v][18:9],
               VEC[v][8:1], VEC[v][0]);
    end
    check_bit("R6 all enabled", ep_enabled == 5'b11111, 1'b1);
    check_bit("R6 alloc kept", ep_alloc == 5'b11101, 1'b1);

    // R8 reserve of a reserved endpoint and release of a free one are ignored
    do_cmd(2'd2, 3'd0, 2'd3, 1'b1);
    check_ep("R8 realloc", 3'd0, 10'd0, 8'd16, 1'b1);
    do_cmd(2'd3, 3'd1, 2'd0, 1'b0);
    check_ep("R8 free unreserved", 3'd2, 10'd16, 8'd64, 1'b1);

    // R9 change visible only after the edge, lookup same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_ep = 3'd1; cmd_size = 2'd0; cmd_bank = 1'b0;
    check_ep("R9 before edge", 3'd1, 10'd0, 8'd0, 1'b0);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    check_ep("R9 after edge", 3'd1, 10'd16, 8'd8, 1'b1);
    check_ep("R4 neighbour", 3'd2, 10'd24, 8'd64, 1'b1);
    check_ep("R4 k+2 stays", 3'd3, 10'd80, 8'd32, 1'b1);
    check_ep("R9 out of range", 3'd7, 10'd0, 8'd0, 1'b0);

    // R7 overflow
    do_cmd(2'd3, 3'd4, 2'd0, 1'b0);
    check_bit("R7 no overflow", overflow, 1'b0);
    do_cmd(2'd2, 3'd4, 2'd3, 1'b1);
    check_ep("R7 past end", 3'd4, 10'd112, 8'd128, 1'b0);
    check_bit("R7 overflow", overflow, 1'b1);
    check_bit("R7 fit vector", ep_cfg_ok == 5'b01111, 1'b1);
    do_cmd(2'd3, 3'd4, 2'd0, 1'b0);
    check_bit("R7 overflow cleared", overflow, 1'b0);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check_bit("R1 alloc after reset", ep_alloc == 5'd0, 1'b1);
    check_ep("R1 after reset", 3'd2, 10'd0, 8'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule